// File: doc/BRIEF.md
# Watchdog Timer with Shared Prescaler

This block is a free-running watchdog with one prescaler that it shares with a general-purpose timer. A single select bit decides which side gets the prescaler. When the watchdog owns it, watchdog clock ticks are divided by 2^n before they reach the watchdog counter, and timer ticks pass straight through. When the timer owns it, the timer ticks are divided and the watchdog counts raw ticks. The block only produces the timer's increment strobe. The timer itself lives elsewhere.

Two strobes come from the instruction decoder. One is the clear-watchdog strobe, decoded from the 12-bit word 0x004, which completes in a single cycle. The other is the sleep strobe. Both reset the watchdog counter and load the time-out and power-down flags. They reset the prescaler only while the watchdog owns it. When the counter wraps, the block raises a one-cycle reset pulse while running, or a one-cycle wake pulse while asleep, and clears the time-out flag. All tick and strobe inputs are single-cycle enables in the `clk` domain. The block has no data stream, so it has no handshake.

Top module: `wdt_top`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `to_flag` and `pd_flag` are 1, `wdt_reset` and `wdt_wake` are 0, and the counter and prescaler hold zero.
- R2: With `ps_to_wdt`=1 and `ps_sel`=n, the counter wraps on the 2^(CNT_W+n)-th `wdt_tick` after a clear. The pulse appears in the cycle after the edge that takes that tick.
- R3: With `ps_to_wdt`=0, the counter wraps on the 2^CNT_W-th `wdt_tick` for every `ps_sel`. `tmr_inc` is high on every 2^n-th `tmr_tick`, counted from a zero prescaler, in the same cycle as that tick.
- R4: With `ps_to_wdt`=1, `tmr_inc` equals `tmr_tick` in every cycle.
- R5: A `clr_wdt` strobe sets `to_flag`=1 and `pd_flag`=1 at the next edge, and restarts the counter from zero.
- R6: A `clr_wdt` strobe while `ps_to_wdt`=0 leaves the prescaler unchanged, so the `tmr_inc` cadence continues without a phase change.
- R7: A `clr_wdt` strobe while `ps_to_wdt`=1 discards partial prescaler progress.
- R8: A wrap while awake gives a one-cycle `wdt_reset` pulse, sets `to_flag`=0 and leaves `pd_flag` unchanged.
- R9: A `sleep_req` strobe sets `to_flag`=1 and `pd_flag`=0. The next wrap gives a one-cycle `wdt_wake` pulse instead of `wdt_reset`, sets `to_flag`=0 and ends sleep, so a later wrap gives `wdt_reset`. `sleep_req` wins over a simultaneous `clr_wdt`.
- R10: `sleep_req` restarts the counter and prescaler in the same way as `clr_wdt`, giving the R2 period.
- R11: A clear or sleep strobe in the cycle of a would-be wrap suppresses that pulse, and the next period counts from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| wdt_tick | input | 1 | Watchdog clock enable, one cycle per tick |
| tmr_tick | input | 1 | Timer source enable, one cycle per tick |
| ps_to_wdt | input | 1 | 1 = prescaler owned by the watchdog, 0 = by the timer |
| ps_sel | input | SEL_W | Prescale exponent n, division by 2^n |
| clr_wdt | input | 1 | Clear-watchdog strobe |
| sleep_req | input | 1 | Sleep strobe |
| wdt_reset | output | 1 | One-cycle reset pulse on wrap while awake |
| wdt_wake | output | 1 | One-cycle wake pulse on wrap while asleep |
| tmr_inc | output | 1 | Increment strobe for the timer |
| to_flag | output | 1 | Time-out flag (0 after a wrap) |
| pd_flag | output | 1 | Power-down flag (0 after sleep) |

## Verification
The hardest state to reach is a clear strobe landing exactly in the cycle where the counter and prescaler both sit at their maximum with a tick present. The bench reaches it by counting edges from a known clear with a tick held every cycle, and raising `clr_wdt` one cycle before the computed wrap edge. Prescaler ownership effects are only visible through timing. The bench therefore measures full wrap periods over every `ps_sel` with partial prescaler progress left in place before each clear, and sweeps the `tmr_inc` cadence across a clear issued while the timer owns the prescaler.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_CLEAR = 2'd1,
    CMD_SLEEP = 2'd2
  } wdt_cmd_e;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_tick,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             out_tick
);
  localparam int PS_W = (1 << SEL_W) - 1;

  generate
    if (SEL_W == 0) begin : g_bypass
      assign out_tick = src_tick & ~clr;
    end else begin : g_div
      logic [PS_W-1:0] ps_q;
      logic [PS_W-1:0] mask;
      logic            wrap;

      // mask = 2^sel - 1, computed without overflow for sel = PS_W
      assign mask     = ~({PS_W{1'b1}} << sel);
      assign wrap     = ((ps_q & mask) == mask);
      assign out_tick = src_tick & wrap & ~clr;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ps_q <= '0;
        end else if (clr) begin
          ps_q <= '0;
        end else if (src_tick) begin
          ps_q <= wrap ? '0 : ps_q + 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic clr,
  output logic ovf
);
  logic [CNT_W-1:0] cnt_q;

  assign ovf = inc & (&cnt_q) & ~clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (inc) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdt_status.sv
module wdt_status
  import wdt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  wdt_cmd_e cmd,
  input  logic     ovf,
  output logic     to_flag,
  output logic     pd_flag,
  output logic     rst_pulse,
  output logic     wake_pulse
);
  logic asleep_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      to_flag    <= 1'b1;
      pd_flag    <= 1'b1;
      asleep_q   <= 1'b0;
      rst_pulse  <= 1'b0;
      wake_pulse <= 1'b0;
    end else begin
      rst_pulse  <= ovf & ~asleep_q;
      wake_pulse <= ovf & asleep_q;
      case (cmd)
        CMD_CLEAR: begin
          to_flag <= 1'b1;
          pd_flag <= 1'b1;
        end
        CMD_SLEEP: begin
          to_flag  <= 1'b1;
          pd_flag  <= 1'b0;
          asleep_q <= 1'b1;
        end
        default: begin
          if (ovf) begin
            to_flag  <= 1'b0;
            asleep_q <= 1'b0;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wdt_tick,
  input  logic             tmr_tick,
  input  logic             ps_to_wdt,
  input  logic [SEL_W-1:0] ps_sel,
  input  logic             clr_wdt,
  input  logic             sleep_req,
  output logic             wdt_reset,
  output logic             wdt_wake,
  output logic             tmr_inc,
  output logic             to_flag,
  output logic             pd_flag
);
  wdt_cmd_e cmd;
  logic     clr_any;
  logic     ps_src;
  logic     ps_clr;
  logic     ps_out;
  logic     cnt_inc;
  logic     cnt_ovf;

  always_comb begin
    if (sleep_req)    cmd = CMD_SLEEP;
    else if (clr_wdt) cmd = CMD_CLEAR;
    else              cmd = CMD_NONE;
  end

  assign clr_any = (cmd != CMD_NONE);
  assign ps_src  = ps_to_wdt ? wdt_tick : tmr_tick;
  assign ps_clr  = clr_any & ps_to_wdt;
  assign cnt_inc = ps_to_wdt ? ps_out : wdt_tick;
  assign tmr_inc = ps_to_wdt ? tmr_tick : ps_out;

  wdt_prescaler #(.SEL_W(SEL_W)) u_ps (
    .clk(clk), .rst_n(rst_n), .src_tick(ps_src), .clr(ps_clr),
    .sel(ps_sel), .out_tick(ps_out)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(cnt_inc), .clr(clr_any), .ovf(cnt_ovf)
  );

  wdt_status u_st (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .ovf(cnt_ovf),
    .to_flag(to_flag), .pd_flag(pd_flag),
    .rst_pulse(wdt_reset), .wake_pulse(wdt_wake)
  );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker (
  input logic clk,
  input logic rst_n,
  input logic tmr_tick,
  input logic ps_to_wdt,
  input logic clr_wdt,
  input logic sleep_req,
  input logic wdt_reset,
  input logic wdt_wake,
  input logic tmr_inc,
  input logic to_flag,
  input logic pd_flag
);
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(wdt_reset && wdt_wake)); // R9
  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset |=> !wdt_reset); // R8
  AST_RST_CLEARS_TO: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_reset || wdt_wake) |-> !to_flag); // R8
  AST_CLR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wdt && !sleep_req) |=> (to_flag && pd_flag)); // R5
  AST_SLEEP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |=> (to_flag && !pd_flag)); // R9
  AST_CLR_BLOCKS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wdt || sleep_req) |=> (!wdt_reset && !wdt_wake)); // R11
  AST_TMR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    ps_to_wdt |-> (tmr_inc == tmr_tick)); // R4
  AST_RST_KEEPS_PD: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_reset && !$past(clr_wdt) && !$past(sleep_req)) |-> $stable(pd_flag)); // R8
endmodule

bind wdt_top wdt_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tmr_tick(tmr_tick), .ps_to_wdt(ps_to_wdt),
  .clr_wdt(clr_wdt), .sleep_req(sleep_req), .wdt_reset(wdt_reset),
  .wdt_wake(wdt_wake), .tmr_inc(tmr_inc), .to_flag(to_flag), .pd_flag(pd_flag)
);

// File: tb/sim_wdt_top.sv
`timescale 1ns/1ps
module sim_wdt_top;
  localparam int CW = 4;
  localparam int SW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wdt_tick = 1'b0, tmr_tick = 1'b0, ps_to_wdt = 1'b0;
  logic [SW-1:0] ps_sel = '0;
  logic clr_wdt = 1'b0, sleep_req = 1'b0;
  logic wdt_reset, wdt_wake, tmr_inc, to_flag, pd_flag;
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  wdt_top #(.CNT_W(CW), .SEL_W(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .wdt_tick(wdt_tick), .tmr_tick(tmr_tick),
    .ps_to_wdt(ps_to_wdt), .ps_sel(ps_sel), .clr_wdt(clr_wdt),
    .sleep_req(sleep_req), .wdt_reset(wdt_reset), .wdt_wake(wdt_wake),
    .tmr_inc(tmr_inc), .to_flag(to_flag), .pd_flag(pd_flag)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Strobe a clear or sleep, then count edges until a pulse is seen.
  task automatic run_period(input bit use_sleep, output int n,
                            output int to_b, output int pd_b);
    @(negedge clk);
    if (use_sleep) sleep_req = 1'b1; else clr_wdt = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
    clr_wdt = 1'b0;
    to_b = int'(to_flag);
    pd_b = int'(pd_flag);
    n = 0;
    while (n < 20000) begin
      @(negedge clk);
      n++;
      if (wdt_reset || wdt_wake) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n, tb, pb;
    do_reset();
    // R1 reset state
    check("R1 to", int'(to_flag), 1);
    check("R1 pd", int'(pd_flag), 1);
    check("R1 reset", int'(wdt_reset), 0);
    check("R1 wake", int'(wdt_wake), 0);

    // R2/R8/R5/R7: prescaler owned by watchdog, sweep every ratio
    ps_to_wdt = 1'b1;
    wdt_tick = 1'b1;
    for (int s = 0; s < 8; s++) begin
      ps_sel = SW'(s);
      repeat (3) @(negedge clk); // partial prescaler progress before clear (R7)
      run_period(1'b0, n, tb, pb);
      check("R2 R7 period", n, 1 << (CW + s));
      check("R5 to after clear", tb, 1);
      check("R5 pd after clear", pb, 1);
      check("R8 reset pulse", int'(wdt_reset), 1);
      check("R8 no wake", int'(wdt_wake), 0);
      check("R8 to cleared", int'(to_flag), 0);
      check("R8 pd kept", int'(pd_flag), 1);
      @(negedge clk);
      check("R8 one cycle", int'(wdt_reset), 0);
    end

    // R3/R5: timer owns prescaler, watchdog counts raw ticks
    ps_to_wdt = 1'b0;
    for (int s = 0; s < 8; s += 5) begin
      ps_sel = SW'(s);
      repeat (10) @(negedge clk);
      run_period(1'b0, n, tb, pb);
      check("R3 R5 raw period", n, 1 << CW);
    end

    // R9/R10: sleep then wake, then a wrap resets again
    ps_to_wdt = 1'b1;
    ps_sel = SW'(1);
    run_period(1'b1, n, tb, pb);
    check("R9 to after sleep", tb, 1);
    check("R9 pd after sleep", pb, 0);
    check("R10 sleep period", n, 1 << (CW + 1));
    check("R9 wake pulse", int'(wdt_wake), 1);
    check("R9 no reset", int'(wdt_reset), 0);
    check("R9 to after wake", int'(to_flag), 0);
    check("R9 pd after wake", int'(pd_flag), 0);
    run_period(1'b0, n, tb, pb);
    check("R9 awake again reset", int'(wdt_reset), 1);
    check("R9 awake again wake", int'(wdt_wake), 0);

    // R9: sleep wins over simultaneous clear
    @(negedge clk);
    sleep_req = 1'b1;
    clr_wdt = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
    clr_wdt = 1'b0;
    check("R9 sleep priority pd", int'(pd_flag), 0);
    run_period(1'b0, n, tb, pb); // clear ends nothing; still asleep
    check("R9 asleep wrap wakes", int'(wdt_wake), 1);

    // R11: clear in the wrap cycle suppresses the pulse
    ps_to_wdt = 1'b0;
    @(negedge clk);
    clr_wdt = 1'b1;
    @(negedge clk);
    clr_wdt = 1'b0;
    repeat (15) @(negedge clk);
    clr_wdt = 1'b1;
    @(negedge clk);
    clr_wdt = 1'b0;
    check("R11 suppressed reset", int'(wdt_reset), 0);
    check("R11 suppressed wake", int'(wdt_wake), 0);
    n = 0;
    while (n < 20000) begin
      @(negedge clk);
      n++;
      if (wdt_reset || wdt_wake) break;
    end
    check("R11 restart period", n, 1 << CW);

    // R3/R6: timer cadence through the prescaler, clear has no effect
    wdt_tick = 1'b0;
    ps_to_wdt = 1'b0;
    for (int s = 0; s < 8; s++) begin
      ps_sel = SW'(s);
      tmr_tick = 1'b0;
      do_reset();
      tmr_tick = 1'b1;
      for (int i = 0; i < 2 * (1 << s) + 2; i++) begin
        clr_wdt = (i == 5) ? 1'b1 : 1'b0;
        #1;
        check((i > 5) ? "R6 cadence after clear" : "R3 timer cadence",
              int'(tmr_inc), ((i % (1 << s)) == (1 << s) - 1) ? 1 : 0);
        @(negedge clk);
      end
      clr_wdt = 1'b0;
    end

    // R4: watchdog owns prescaler, timer passes through
    ps_to_wdt = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tmr_tick = logic'(i[0] ^ i[1]);
      #1;
      check("R4 passthrough", int'(tmr_inc), int'(tmr_tick));
      @(negedge clk);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule